// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small processor built around one accumulator. It runs every instruction as a fixed chain of register transfers. The transfers move values between a program counter, a memory address register, a memory data register, an instruction register and the accumulator. Each instruction word is fetched from a word-addressed synchronous memory. The core then walks through the execute chain picked by the word's opcode and returns to fetching.

Data enters through an input port and leaves through an output port. Each port shows the device number taken from the instruction and uses a valid/ready handshake. Program flow is steered by a jump and by three conditional skips. Each skip tests one of three sign flags (zero, positive, negative), which are refreshed by every accumulator-writing operation.

The core is meant to be embedded next to a single-port memory. It runs from address 0 after reset and raises a halted status when it meets a stop opcode.

Top module: `acc_core`

## Requirements
- R1: While reset is held and directly after it, `halted`, `mem_we`, `in_ready` and `out_valid` are 0, `mem_addr` is 0, and the first instruction executed is the word at address 0. The accumulator and the flags start at 0.
- R2: An instruction word holds the opcode in bits 15:12 and the address or device field in bits 11:0. Opcode 0001 copies memory[field] into the accumulator. Opcode 0010 adds memory[field] to it and opcode 0100 subtracts memory[field] from it, both modulo 2^16.
- R3: Opcode 0011 writes the accumulator to memory[field] with one `mem_we` pulse. No other opcode writes memory.
- R4: After 0001, 0010, 0100 or 0101, exactly one flag is set, judged on the 16-bit two's-complement result: Z if it is zero, N if bit 15 is 1, P otherwise. Opcodes 0011, 0110 and 1000 leave the flags unchanged.
- R5: Opcodes 1001, 1010 and 1011 skip the next instruction word when Z, P or N is set, respectively. Otherwise execution continues at the next word.
- R6: Opcode 1000 continues execution at the address in the field.
- R7: Opcode 0101 raises `in_ready` with `in_dev` equal to the field. It holds both until the cycle in which `in_valid` is 1, loads `in_data` into the accumulator in that cycle, and performs exactly one transfer.
- R8: Opcode 0110 raises `out_valid` with `out_data` equal to the accumulator and `out_dev` equal to the field. It holds all three stable until the cycle in which `out_ready` is 1, and performs exactly one transfer.
- R9: Opcodes 0111, 0000 and 1100 to 1111 stop the core. `halted` then stays 1 until reset, and no memory write or port transfer follows.
- R10: A program that loads 1245 from one location, adds 1755 from a second and stores the sum into a third leaves 3000 in the third location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | ADDR_W | Memory word address (memory address register) |
| mem_wdata | output | DATA_W | Memory write data (memory data register) |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after the address |
| in_dev | output | ADDR_W | Device number for the input transfer |
| in_ready | output | 1 | Core waits for an input word |
| in_valid | input | 1 | Input word offered |
| in_data | input | DATA_W | Input word |
| out_dev | output | ADDR_W | Device number for the output transfer |
| out_valid | output | 1 | Core offers an output word |
| out_ready | input | 1 | Output word accepted |
| out_data | output | DATA_W | Output word (accumulator) |
| halted | output | 1 | Core has stopped |

## Verification
The two functions that can share a cycle are a port request and the partner's response. A handshake may complete in the very first cycle of the IN or OUT execute state, and that same cycle also writes the accumulator (input) or advances to fetch (output). The bench runs the port traffic in three modes: partner always ready, partner ready on random coin flips, and partner mostly absent. The words and device numbers the core transfers are compared against an instruction-level model, and the count of transfers must match exactly. A double or missed transfer on a zero-wait handshake therefore shows up as a count or value mismatch.

// File: rtl/acc_pkg.sv
package acc_pkg;

   // opcode values in bits 15:12 of an instruction word
   localparam logic [3:0] OPC_RD   = 4'h1;
   localparam logic [3:0] OPC_ADD  = 4'h2;
   localparam logic [3:0] OPC_WR   = 4'h3;
   localparam logic [3:0] OPC_SUB  = 4'h4;
   localparam logic [3:0] OPC_PIN  = 4'h5;
   localparam logic [3:0] OPC_POUT = 4'h6;
   localparam logic [3:0] OPC_STOP = 4'h7;
   localparam logic [3:0] OPC_GOTO = 4'h8;
   localparam logic [3:0] OPC_SKZ  = 4'h9;
   localparam logic [3:0] OPC_SKP  = 4'hA;
   localparam logic [3:0] OPC_SKN  = 4'hB;

   typedef struct packed {
      logic z;
      logic p;
      logic n;
   } flags_t;

   typedef enum logic [1:0] {ALU_PASS, ALU_ADD, ALU_SUB} alu_op_e;

   typedef enum logic [3:0] {
      ST_FMAR, ST_FWAIT, ST_FMDR, ST_FIR, ST_DEC,
      ST_XMAR, ST_XWAIT, ST_XMDR, ST_XALU,
      ST_SMDR, ST_SWR, ST_IN, ST_OUT, ST_HALT
   } state_e;

   typedef struct packed {
      logic    mar_from_pc;
      logic    mar_from_ir;
      logic    mdr_from_mem;
      logic    mdr_from_acc;
      logic    ir_load;
      logic    pc_inc;
      logic    pc_jump;
      logic    acc_load;
      logic    b_from_in;
      alu_op_e alu_sel;
      logic    mem_we;
      logic    in_ready;
      logic    out_valid;
      logic    halted;
   } ctrl_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu import acc_pkg::*; #(
   parameter int W            = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      sel,
   output logic [W-1:0] res,
   output flags_t       flg
);

   logic [W-1:0] arith;

   generate
      if (SHARED_ADDER) begin : g_shared
         // one adder: subtraction through inverted operand and carry-in
         logic          neg;
         logic [W-1:0]  b_x;
         assign neg   = (sel == ALU_SUB);
         assign b_x   = b ^ {W{neg}};
         assign arith = a + b_x + {{(W-1){1'b0}}, neg};
      end else begin : g_split
         logic [W-1:0] sum_v;
         logic [W-1:0] dif_v;
         assign sum_v = a + b;
         assign dif_v = a - b;
         assign arith = (sel == ALU_SUB) ? dif_v : sum_v;
      end
   endgenerate

   assign res   = (sel == ALU_PASS) ? b : arith;
   assign flg.z = (res == '0);
   assign flg.n = res[W-1];
   assign flg.p = (res != '0) && !res[W-1];

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl import acc_pkg::*; (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] op,
   input  flags_t     flg,
   input  logic       in_valid,
   input  logic       out_ready,
   output ctrl_t      ctl
);

   state_e state, nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_FMAR;
      else        state <= nxt;
   end

   always_comb begin
      ctl = '0;
      nxt = state;
      unique case (state)
         ST_FMAR:  begin ctl.mar_from_pc = 1'b1; nxt = ST_FWAIT; end
         ST_FWAIT: nxt = ST_FMDR;
         ST_FMDR:  begin ctl.mdr_from_mem = 1'b1; nxt = ST_FIR; end
         ST_FIR:   begin ctl.ir_load = 1'b1; ctl.pc_inc = 1'b1; nxt = ST_DEC; end
         ST_DEC: begin
            nxt = ST_FMAR;
            case (op)
               OPC_RD, OPC_ADD, OPC_WR, OPC_SUB: nxt = ST_XMAR;
               OPC_PIN:  nxt = ST_IN;
               OPC_POUT: nxt = ST_OUT;
               OPC_GOTO: ctl.pc_jump = 1'b1;
               OPC_SKZ:  ctl.pc_inc = flg.z;
               OPC_SKP:  ctl.pc_inc = flg.p;
               OPC_SKN:  ctl.pc_inc = flg.n;
               default:  nxt = ST_HALT;
            endcase
         end
         ST_XMAR: begin
            ctl.mar_from_ir = 1'b1;
            nxt = (op == OPC_WR) ? ST_SMDR : ST_XWAIT;
         end
         ST_XWAIT: nxt = ST_XMDR;
         ST_XMDR:  begin ctl.mdr_from_mem = 1'b1; nxt = ST_XALU; end
         ST_XALU: begin
            ctl.acc_load = 1'b1;
            ctl.alu_sel  = (op == OPC_ADD) ? ALU_ADD :
                           (op == OPC_SUB) ? ALU_SUB : ALU_PASS;
            nxt = ST_FMAR;
         end
         ST_SMDR: begin ctl.mdr_from_acc = 1'b1; nxt = ST_SWR; end
         ST_SWR:  begin ctl.mem_we = 1'b1; nxt = ST_FMAR; end
         ST_IN: begin
            ctl.in_ready  = 1'b1;
            ctl.b_from_in = 1'b1;
            if (in_valid) begin
               ctl.acc_load = 1'b1;
               nxt = ST_FMAR;
            end
         end
         ST_OUT: begin
            ctl.out_valid = 1'b1;
            if (out_ready) nxt = ST_FMAR;
         end
         ST_HALT: ctl.halted = 1'b1;
         default: nxt = ST_FMAR;
      endcase
   end

   // R3/R7/R8/R9: at most one external action per cycle
   a_r9_one_action: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctl.mem_we, ctl.in_ready, ctl.out_valid, ctl.halted}));

   // R2: a memory-sourced accumulator update follows a memory read into the data register
   a_r2_operand_read: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.acc_load && !ctl.b_from_in) |-> $past(ctl.mdr_from_mem));

endmodule

// File: rtl/acc_core.sv
module acc_core import acc_pkg::*; #(
   parameter int ADDR_W       = 12,
   parameter int DATA_W       = 16,
   parameter int OPC_W        = 4,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] in_dev,
   output logic              in_ready,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic [ADDR_W-1:0] out_dev,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              halted
);

   localparam int OP_LSB = DATA_W - OPC_W;

   generate
      if (OPC_W != 4) begin : g_bad_opc
         $error("acc_core: opcode field must be 4 bits");
      end
      if (DATA_W != OPC_W + ADDR_W) begin : g_bad_word
         $error("acc_core: word width must equal opcode plus field width");
      end
   endgenerate

   logic [ADDR_W-1:0] pc, mar;
   logic [DATA_W-1:0] mdr, ir, acc;
   flags_t            flg;

   logic [3:0]        op;
   logic [ADDR_W-1:0] field;
   ctrl_t             ctl;
   logic [DATA_W-1:0] alu_b, alu_res;
   flags_t            alu_flg;

   assign op    = ir[DATA_W-1:OP_LSB];
   assign field = ir[ADDR_W-1:0];
   assign alu_b = ctl.b_from_in ? in_data : mdr;

   acc_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .flg       (flg),
      .in_valid  (in_valid),
      .out_ready (out_ready),
      .ctl       (ctl)
   );

   acc_alu #(.W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .a   (acc),
      .b   (alu_b),
      .sel (ctl.alu_sel),
      .res (alu_res),
      .flg (alu_flg)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc  <= '0;
         mar <= '0;
         mdr <= '0;
         ir  <= '0;
         acc <= '0;
         flg <= '0;
      end else begin
         if (ctl.mar_from_pc)       mar <= pc;
         else if (ctl.mar_from_ir)  mar <= field;
         if (ctl.mdr_from_mem)      mdr <= mem_rdata;
         else if (ctl.mdr_from_acc) mdr <= acc;
         if (ctl.ir_load)           ir  <= mdr;
         if (ctl.pc_jump)           pc  <= field;
         else if (ctl.pc_inc)       pc  <= pc + 1'b1;
         if (ctl.acc_load) begin
            acc <= alu_res;
            flg <= alu_flg;
         end
      end
   end

   assign mem_addr  = mar;
   assign mem_wdata = mdr;
   assign mem_we    = ctl.mem_we;
   assign in_dev    = field;
   assign in_ready  = ctl.in_ready;
   assign out_dev   = field;
   assign out_valid = ctl.out_valid;
   assign out_data  = acc;
   assign halted    = ctl.halted;

   // R4: never more than one flag, exactly one after a result
   a_r4_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(flg));
   a_r4_flag_after_result: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.acc_load |=> ($countones(flg) == 1));

   // R3: the stored word is the accumulator
   a_r3_store_value: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_wdata == acc));

   // R7: input request held until accepted
   a_r7_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> (in_ready && $stable(in_dev)));

   // R8: output offer held stable until accepted
   a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_dev)));

   // R9: stop is permanent
   a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

endmodule

// File: tb/acc_core_test.sv
module acc_core_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] mem_addr, in_dev, out_dev;
   logic [15:0] mem_wdata, mem_rdata, in_data, out_data;
   logic        mem_we, in_ready, in_valid, out_valid, out_ready, halted;

   always #5 clk = ~clk;

   acc_core uut (
      .clk(clk), .rst_n(rst_n),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
      .in_dev(in_dev), .in_ready(in_ready), .in_valid(in_valid), .in_data(in_data),
      .out_dev(out_dev), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .halted(halted)
   );

   int checks = 0;
   int errors = 0;
   int hs_mode = 0;

   logic [15:0] mem [256];
   logic [15:0] img [256];
   logic        img_load = 1'b0;
   logic [15:0] in_vals [64];

   // synchronous single-port memory
   always @(posedge clk) begin
      if (img_load) begin
         for (int i = 0; i < 256; i++) mem[i] <= img[i];
      end else if (mem_we) begin
         mem[mem_addr[7:0]] <= mem_wdata;
      end
      mem_rdata <= mem[mem_addr[7:0]];
   end

   // port partner and transfer monitor
   int          in_n, out_n, wr_n;
   logic [15:0] out_got [64];
   logic [11:0] odev_got [64];
   logic [11:0] idev_got [64];

   assign in_data = in_vals[in_n[5:0]];

   always @(posedge clk) begin
      if (!rst_n) begin
         in_n <= 0; out_n <= 0; wr_n <= 0;
      end else begin
         if (in_ready && in_valid && in_n < 64) begin
            idev_got[in_n] <= in_dev;
            in_n <= in_n + 1;
         end
         if (out_valid && out_ready && out_n < 64) begin
            out_got[out_n]  <= out_data;
            odev_got[out_n] <= out_dev;
            out_n <= out_n + 1;
         end
         if (mem_we) wr_n <= wr_n + 1;
      end
   end

   always @(negedge clk) begin
      case (hs_mode)
         0: begin in_valid <= 1'b1; out_ready <= 1'b1; end
         1: begin in_valid <= (($urandom % 2) == 1); out_ready <= (($urandom % 2) == 1); end
         default: begin in_valid <= (($urandom % 6) == 0); out_ready <= (($urandom % 6) == 0); end
      endcase
   end

   // instruction-level reference model
   logic [15:0] rmem [256];
   logic [15:0] e_out [64];
   logic [11:0] e_odev [64];
   logic [11:0] e_idev [64];
   int          e_in_n, e_out_n, e_wr_n;

   function automatic logic [2:0] sign_flags(logic [15:0] v);
      return {v == 16'h0, (v != 16'h0) && !v[15], v[15]};
   endfunction

   function automatic logic [15:0] iw(logic [3:0] o, logic [11:0] f);
      return {o, f};
   endfunction

   task automatic ref_run();
      logic [11:0] pc = '0;
      logic [15:0] a = '0;
      logic [15:0] w;
      logic [2:0]  f = '0;
      bit          run = 1'b1;
      for (int i = 0; i < 256; i++) rmem[i] = img[i];
      e_in_n = 0; e_out_n = 0; e_wr_n = 0;
      for (int s = 0; s < 600 && run; s++) begin
         w  = rmem[pc[7:0]];
         pc = pc + 12'd1;
         case (w[15:12])
            4'h1: begin a = rmem[w[7:0]]; f = sign_flags(a); end
            4'h2: begin a = a + rmem[w[7:0]]; f = sign_flags(a); end
            4'h3: begin rmem[w[7:0]] = a; e_wr_n++; end
            4'h4: begin a = a - rmem[w[7:0]]; f = sign_flags(a); end
            4'h5: begin
               a = in_vals[e_in_n[5:0]]; f = sign_flags(a);
               e_idev[e_in_n] = w[11:0]; e_in_n++;
            end
            4'h6: begin e_out[e_out_n] = a; e_odev[e_out_n] = w[11:0]; e_out_n++; end
            4'h8: pc = w[11:0];
            4'h9: if (f[2]) pc = pc + 12'd1;
            4'hA: if (f[1]) pc = pc + 12'd1;
            4'hB: if (f[0]) pc = pc + 12'd1;
            default: run = 1'b0;
         endcase
      end
   endtask

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic clear_img();
      for (int i = 0; i < 256; i++) img[i] = 16'h0;
      for (int i = 0; i < 64; i++) in_vals[i] = 16'($urandom);
   endtask

   task automatic run_case(string tag);
      int bad;
      int first;
      ref_run();
      @(negedge clk);
      rst_n = 1'b0;
      img_load = 1'b1;
      @(negedge clk);
      img_load = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int c = 0; c < 4000 && !halted; c++) @(negedge clk);
      repeat (8) @(negedge clk);
      chk(halted == 1'b1, tag, "halted", int'(halted), 1);
      chk(out_n == e_out_n, tag, "output transfer count", out_n, e_out_n);
      for (int i = 0; i < e_out_n && i < out_n; i++) begin
         chk(out_got[i] == e_out[i], tag, "output word", int'(out_got[i]), int'(e_out[i]));
         chk(odev_got[i] == e_odev[i], tag, "output device", int'(odev_got[i]), int'(e_odev[i]));
      end
      chk(in_n == e_in_n, tag, "input transfer count", in_n, e_in_n);
      for (int i = 0; i < e_in_n && i < in_n; i++)
         chk(idev_got[i] == e_idev[i], tag, "input device", int'(idev_got[i]), int'(e_idev[i]));
      chk(wr_n == e_wr_n, tag, "memory write count", wr_n, e_wr_n);
      bad = 0; first = 0;
      for (int i = 255; i >= 0; i--)
         if (mem[i] !== rmem[i]) begin bad++; first = i; end
      chk(bad == 0, tag, "memory image mismatching words", bad, 0);
      if (bad != 0) $display("  first mismatch at %0d: %0h vs %0h", first, mem[first], rmem[first]);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0C0D));
      clear_img();

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(halted == 1'b0,    "R1", "halted in reset", int'(halted), 0);
      chk(mem_we == 1'b0,    "R1", "mem_we in reset", int'(mem_we), 0);
      chk(in_ready == 1'b0,  "R1", "in_ready in reset", int'(in_ready), 0);
      chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
      chk(mem_addr == 12'h0, "R1", "mem_addr in reset", int'(mem_addr), 0);

      // R10 / R2 / R3: 1245 + 1755
      clear_img();
      img[0] = iw(4'h1, 12'd100);
      img[1] = iw(4'h2, 12'd101);
      img[2] = iw(4'h3, 12'd102);
      img[3] = iw(4'h7, 12'd0);
      img[100] = 16'd1245; img[101] = 16'd1755;
      hs_mode = 0;
      run_case("R10 sum program");
      chk(mem[102] == 16'd3000, "R10", "stored sum", int'(mem[102]), 3000);

      // R4 / R5: each flag, overflow wrap to negative, skips taken and not taken
      clear_img();
      img[0]  = iw(4'h1, 12'd100);  // zero
      img[1]  = iw(4'h9, 12'd0);
      img[2]  = iw(4'h6, 12'd9);    // skipped
      img[3]  = iw(4'hA, 12'd0);    // not taken
      img[4]  = iw(4'h6, 12'd7);
      img[5]  = iw(4'h1, 12'd101);  // 7FFF
      img[6]  = iw(4'h2, 12'd102);  // +1 -> 8000
      img[7]  = iw(4'hB, 12'd0);
      img[8]  = iw(4'h7, 12'd0);    // skipped
      img[9]  = iw(4'h9, 12'd0);    // not taken
      img[10] = iw(4'h6, 12'd5);
      img[11] = iw(4'h4, 12'd102);  // -> 7FFF
      img[12] = iw(4'hA, 12'd0);
      img[13] = iw(4'h7, 12'd0);    // skipped
      img[14] = iw(4'h6, 12'd9);
      img[15] = iw(4'h7, 12'd0);
      img[100] = 16'h0000; img[101] = 16'h7FFF; img[102] = 16'h0001;
      run_case("R4 R5 R2 flags and skips");
      chk(out_n == 3, "R5", "outputs after skips", out_n, 3);

      // R4 / R6: flags survive store, output and jump
      clear_img();
      img[0] = iw(4'h1, 12'd100);   // FFFF, negative
      img[1] = iw(4'h3, 12'd103);
      img[2] = iw(4'h6, 12'd7);
      img[3] = iw(4'h8, 12'd5);
      img[4] = iw(4'h7, 12'd0);     // jumped over
      img[5] = iw(4'hB, 12'd0);
      img[6] = iw(4'h7, 12'd0);     // skipped
      img[7] = iw(4'h6, 12'd9);
      img[8] = iw(4'h7, 12'd0);
      img[100] = 16'hFFFF;
      run_case("R4 R6 flag hold and jump");
      chk(out_n == 2, "R6", "outputs after jump", out_n, 2);

      // R7 / R8: port traffic under three partner behaviours
      for (int m = 0; m < 3; m++) begin
         clear_img();
         img[0] = iw(4'h5, 12'd5);
         img[1] = iw(4'h6, 12'd7);
         img[2] = iw(4'h5, 12'd9);
         img[3] = iw(4'h2, 12'd100);
         img[4] = iw(4'h6, 12'd9);
         img[5] = iw(4'h3, 12'd104);
         img[6] = iw(4'h7, 12'd0);
         img[100] = 16'd42;
         hs_mode = m;
         run_case("R7 R8 port handshake");
      end

      // R9: every stop opcode
      for (int k = 0; k < 6; k++) begin
         logic [3:0] sop;
         sop = (k == 0) ? 4'h7 : (k == 1) ? 4'h0 : 4'(k + 10);
         clear_img();
         img[0] = iw(4'h6, 12'd5);
         img[1] = iw(sop, 12'h0AB);
         img[2] = iw(4'h6, 12'd7);
         img[3] = iw(4'h3, 12'd100);
         hs_mode = k % 3;
         run_case("R9 stop opcode");
         chk(out_n == 1, "R9", "outputs before stop", out_n, 1);
      end

      // random forward-only programs
      for (int t = 0; t < 10; t++) begin
         clear_img();
         for (int pc = 0; pc < 24; pc++) begin
            int r;
            logic [11:0] d, dv;
            r  = int'($urandom % 12);
            d  = 12'(128 + ($urandom % 16));
            dv = ($urandom % 3 == 0) ? 12'd5 : ($urandom % 2 == 0) ? 12'd7 : 12'd9;
            case (r)
               0, 10: img[pc] = iw(4'h1, d);
               1, 11: img[pc] = iw(4'h2, d);
               2: img[pc] = iw(4'h4, d);
               3: img[pc] = iw(4'h3, d);
               4: img[pc] = iw(4'h5, dv);
               5: img[pc] = iw(4'h6, dv);
               6: img[pc] = iw(4'h9, 12'd0);
               7: img[pc] = iw(4'hA, 12'd0);
               8: img[pc] = iw(4'hB, 12'd0);
               default: img[pc] = iw(4'h8, 12'(pc + 1 + int'($urandom % 3)));
            endcase
         end
         for (int i = 24; i < 28; i++) img[i] = iw(4'h7, 12'd0);
         for (int i = 128; i < 144; i++) begin
            case ($urandom % 4)
               0: img[i] = 16'h0000;
               1: img[i] = 16'h7FFF;
               2: img[i] = 16'h8000;
               default: img[i] = 16'($urandom);
            endcase
         end
         hs_mode = t % 3;
         run_case("R2 R3 R4 R5 R6 R7 R8 random program");
      end

      summary();
      $finish;
   end

endmodule